// File: doc/BRIEF.md
# Set-Associative Line Cache with Command Decode

This block is the storage half of a cache. It holds an address (tag) array and a line data array side by side, and a surrounding controller drives it one command per clock. Each command comes from the pattern on four control inputs, together with an address that names a whole line. The block answers lookups with hit or miss. It reads and byte-updates lines in place, and it can drop a line after a read or write. It also carries out a two-step replacement that first hands the evicted line and its address back to the controller, then installs the new line.

The line count, the associativity, the address width, the line width and the hit/miss timing are parameters. Lines are grouped into sets, and the low address bits pick the set. Each set keeps a full age ordering of its ways, and the replacement victim comes from that ordering. The controller handles refill and write-back, using the victim data that the block returns.

Top module: `cache_assoc`

## Requirements
- R1: The pattern {req_i, rw_i, inv_i, rep_i} selects the command: 1000 read, 1100 update, 1010 read-then-drop, 1110 write-then-drop, 0001 victim read, 0101 victim write. Every other pattern, 0000 included, is a no-op: no hit or miss is raised, line_o and old_addr_o hold, and no stored state changes.
- R2: The set is the low log2(LINES/WAYS) address bits, or the only set when LINES equals WAYS. A lookup hits only when a valid way of that set holds exactly the presented address.
- R3: Synchronous reset clears all valid bits and drives hit_o, miss_o, line_o and old_addr_o to 0. Every lookup after reset misses until a line is installed.
- R4: For each command with req_i=1 and rep_i=0, exactly one of hit_o and miss_o is 1: one cycle later when HIT_REG=1, or in the same cycle when HIT_REG=0. Both are 0 for every other command.
- R5: A read hit drives the stored line on line_o one cycle later. A read miss leaves line_o unchanged.
- R6: An update hit writes byte b (bits 8b+7..8b) only where wmask_n_i[b]=0, and keeps the other bytes. The merged line appears on line_o one cycle later. An update miss changes neither data nor addresses.
- R7: A victim read drives the victim's stored line on line_o and its stored address on old_addr_o one cycle later. old_addr_o changes after no other command.
- R8: A victim write stores all bytes of line_i whatever wmask_n_i holds. It marks the presented address valid in the victim way and shows line_i on line_o one cycle later.
- R9: The victim is the lowest-numbered invalid way of the addressed set. When every way is valid, it is the least recently used way.
- R10: After reset, each set's age order runs from way 0 (oldest) to way WAYS-1 (newest). A read or update hit, and a victim write, make the way the newest.
- R11: A read-then-drop or write-then-drop hit returns data as a read or update would. It clears that way's valid bit and makes the way the oldest. On a miss nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Command bit: lookup request |
| rw_i | input | 1 | Command bit: write when 1 |
| inv_i | input | 1 | Command bit: drop line after access |
| rep_i | input | 1 | Command bit: replacement step |
| wmask_n_i | input | DATA_W/8 | Active-low byte write mask |
| addr_i | input | ADDR_W | Line address |
| line_i | input | DATA_W | Line data to write |
| line_o | output | DATA_W | Line data, one cycle after access |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| old_addr_o | output | ADDR_W | Address of the line chosen as victim |

## Verification
Two functions can act on the same way in one cycle: a hit that changes the age ordering, and the victim choice that reads that same ordering. In the bench, sixteen addresses compete for two sets of four ways. Reads, masked updates and drop commands are interleaved with victim read/write pairs, so each replacement depends on which way a recent hit promoted or a drop demoted. A reference model in the bench, built from the requirements, predicts the victim address and data, the hit/miss result and every merged line, and each of these is compared at the ports.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_READ,
        CMD_UPDATE,
        CMD_READ_DROP,
        CMD_WRITE_DROP,
        CMD_VIC_READ,
        CMD_VIC_WRITE
    } cmd_e;

    function automatic cmd_e decode_cmd(input logic req, input logic rw,
                                        input logic inv, input logic rep);
        cmd_e c;
        case ({req, rw, inv, rep})
            4'b1000: c = CMD_READ;
            4'b1100: c = CMD_UPDATE;
            4'b1010: c = CMD_READ_DROP;
            4'b1110: c = CMD_WRITE_DROP;
            4'b0001: c = CMD_VIC_READ;
            4'b0101: c = CMD_VIC_WRITE;
            default: c = CMD_NOP;
        endcase
        return c;
    endfunction

    function automatic logic is_lookup(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_UPDATE) ||
               (c == CMD_READ_DROP) || (c == CMD_WRITE_DROP);
    endfunction

    function automatic logic is_lookup_write(input cmd_e c);
        return (c == CMD_UPDATE) || (c == CMD_WRITE_DROP);
    endfunction

endpackage

// File: rtl/cache_tag_unit.sv
module cache_tag_unit
    import cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SETS   = 1,
    parameter int WAYS   = 32,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SET_W-1:0]  set_o,
    output logic              hit_o,
    output logic [WAY_W-1:0]  hit_way_o,
    output logic [WAY_W-1:0]  victim_way_o,
    output logic [ADDR_W-1:0] victim_addr_o
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [ADDR_W-1:0] tag_q   [SETS][WAYS];
    logic [WAY_W-1:0]  rank_q  [SETS][WAYS];

    logic [SET_W-1:0] set_idx;

    generate
        if (SETS > 1) begin : g_multi_set
            assign set_idx = addr_i[SET_W-1:0];
        end else begin : g_single_set
            assign set_idx = '0;
        end
    endgenerate

    // lookup
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid_q[set_idx][w] && (tag_q[set_idx][w] == addr_i)) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

    // victim: lowest invalid way, else the oldest way
    logic             any_free;
    logic [WAY_W-1:0] free_way, old_way, victim;
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        old_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[set_idx][w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
            if (rank_q[set_idx][w] == '0) begin
                old_way = WAY_W'(w);
            end
        end
        victim = any_free ? free_way : old_way;
    end

    // state update decision
    logic             touch, to_newest, install, drop;
    logic [WAY_W-1:0] touch_way, touch_rank;
    always_comb begin
        touch     = 1'b0;
        to_newest = 1'b1;
        install   = 1'b0;
        drop      = 1'b0;
        touch_way = hit_way;
        case (cmd_i)
            CMD_READ, CMD_UPDATE: touch = hit;
            CMD_READ_DROP, CMD_WRITE_DROP: begin
                touch     = hit;
                drop      = hit;
                to_newest = 1'b0;
            end
            CMD_VIC_WRITE: begin
                touch     = 1'b1;
                install   = 1'b1;
                touch_way = victim;
            end
            default: ;
        endcase
        touch_rank = rank_q[set_idx][touch_way];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    rank_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            if (install) valid_q[set_idx][touch_way] <= 1'b1;
            if (drop)    valid_q[set_idx][touch_way] <= 1'b0;
            if (touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way) begin
                        rank_q[set_idx][w] <= to_newest ? WAY_W'(WAYS - 1) : '0;
                    end else if (to_newest && (rank_q[set_idx][w] > touch_rank)) begin
                        rank_q[set_idx][w] <= rank_q[set_idx][w] - 1'b1;
                    end else if (!to_newest && (rank_q[set_idx][w] < touch_rank)) begin
                        rank_q[set_idx][w] <= rank_q[set_idx][w] + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) tag_q[set_idx][touch_way] <= addr_i;
    end

    assign set_o         = set_idx;
    assign hit_o         = hit;
    assign hit_way_o     = hit_way;
    assign victim_way_o  = victim;
    assign victim_addr_o = tag_q[set_idx][victim];

endmodule

// File: rtl/cache_line_ram.sv
module cache_line_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              we_i,
    input  logic [BYTES-1:0]  be_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = mem[idx_i];
        for (int b = 0; b < BYTES; b++) begin
            if (we_i && be_i[b]) merged[b*8 +: 8] = wdata_i[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (en_i && we_i) mem[idx_i] <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst)       rdata_o <= '0;
        else if (en_i) rdata_o <= merged;
    end

endmodule

// File: rtl/cache_assoc.sv
module cache_assoc
    import cache_pkg::*;
#(
    parameter int LINES   = 32,
    parameter int WAYS    = 32,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter bit HIT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_i,
    input  logic                  rw_i,
    input  logic                  inv_i,
    input  logic                  rep_i,
    input  logic [DATA_W/8-1:0]   wmask_n_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     line_i,
    output logic [DATA_W-1:0]     line_o,
    output logic                  hit_o,
    output logic                  miss_o,
    output logic [ADDR_W-1:0]     old_addr_o
);

    localparam int SETS  = LINES / WAYS;
    localparam int BYTES = DATA_W / 8;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    cmd_e              cmd;
    logic [SET_W-1:0]  set_idx;
    logic              tag_hit;
    logic [WAY_W-1:0]  hit_way, victim_way, way_sel;
    logic [ADDR_W-1:0] victim_addr;
    logic              lookup, ram_en, ram_we;
    logic [BYTES-1:0]  ram_be;
    logic [IDX_W-1:0]  row;

    assign cmd = decode_cmd(req_i, rw_i, inv_i, rep_i);

    cache_tag_unit #(
        .ADDR_W(ADDR_W),
        .SETS  (SETS),
        .WAYS  (WAYS)
    ) u_tags (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .addr_i       (addr_i),
        .set_o        (set_idx),
        .hit_o        (tag_hit),
        .hit_way_o    (hit_way),
        .victim_way_o (victim_way),
        .victim_addr_o(victim_addr)
    );

    assign lookup  = is_lookup(cmd);
    assign way_sel = lookup ? hit_way : victim_way;
    assign ram_en  = (lookup && tag_hit) || (cmd == CMD_VIC_READ) || (cmd == CMD_VIC_WRITE);
    assign ram_we  = (is_lookup_write(cmd) && tag_hit) || (cmd == CMD_VIC_WRITE);
    assign ram_be  = (cmd == CMD_VIC_WRITE) ? '1 : ~wmask_n_i;
    assign row     = IDX_W'(32'(set_idx) * WAYS + 32'(way_sel));

    cache_line_ram #(
        .DATA_W(DATA_W),
        .DEPTH (LINES)
    ) u_ram (
        .clk    (clk),
        .rst    (rst),
        .en_i   (ram_en),
        .we_i   (ram_we),
        .be_i   (ram_be),
        .idx_i  (row),
        .wdata_i(line_i),
        .rdata_o(line_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                      old_addr_o <= '0;
        else if (cmd == CMD_VIC_READ) old_addr_o <= victim_addr;
    end

    logic hit_c, miss_c;
    assign hit_c  = lookup && tag_hit;
    assign miss_c = lookup && !tag_hit;

    generate
        if (HIT_REG) begin : g_hit_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    hit_o  <= 1'b0;
                    miss_o <= 1'b0;
                end else begin
                    hit_o  <= hit_c;
                    miss_o <= miss_c;
                end
            end
        end else begin : g_hit_comb
            assign hit_o  = hit_c;
            assign miss_o = miss_c;
        end
    endgenerate

endmodule

// File: rtl/cache_assoc_chk.sv
module cache_assoc_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter bit HIT_REG = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              rw_i,
    input logic              inv_i,
    input logic              rep_i,
    input logic [DATA_W-1:0] line_i,
    input logic [DATA_W-1:0] line_o,
    input logic              hit_o,
    input logic              miss_o,
    input logic [ADDR_W-1:0] old_addr_o
);

    logic is_req, is_vic_rd, is_vic_wr;
    assign is_req    = req_i && !rep_i;
    assign is_vic_rd = !req_i && !rw_i && !inv_i && rep_i;
    assign is_vic_wr = !req_i && rw_i && !inv_i && rep_i;

    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(hit_o && miss_o)); // R4

    generate
        if (HIT_REG) begin : g_reg
            AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
                is_req |=> (hit_o ^ miss_o)); // R4
            AST_NO_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
                !is_req |=> !(hit_o || miss_o)); // R4
        end else begin : g_comb
            AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (rst)
                is_req |-> (hit_o ^ miss_o)); // R4
            AST_NO_LOOKUP_QUIET: assert property (@(posedge clk) disable iff (rst)
                !is_req |-> !(hit_o || miss_o)); // R4
        end
    endgenerate

    AST_OLD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !is_vic_rd |=> $stable(old_addr_o)); // R7

    AST_VIC_WRITE_ECHO: assert property (@(posedge clk) disable iff (rst)
        is_vic_wr |=> (line_o == $past(line_i))); // R8

endmodule

bind cache_assoc cache_assoc_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HIT_REG(HIT_REG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_i),
    .rw_i      (rw_i),
    .inv_i     (inv_i),
    .rep_i     (rep_i),
    .line_i    (line_i),
    .line_o    (line_o),
    .hit_o     (hit_o),
    .miss_o    (miss_o),
    .old_addr_o(old_addr_o)
);

// File: tb/cache_assoc_tb.sv
`timescale 1ns/1ps
module cache_assoc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i, rw_i, inv_i, rep_i;
    logic [1:0]  wmask_n_i;
    logic [3:0]  addr_i;
    logic [15:0] line_i, line_o;
    logic        hit_o, miss_o;
    logic [3:0]  old_addr_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cache_assoc #(
        .LINES(8), .WAYS(4), .ADDR_W(4), .DATA_W(16), .HIT_REG(1'b1)
    ) u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .rw_i(rw_i), .inv_i(inv_i),
        .rep_i(rep_i), .wmask_n_i(wmask_n_i), .addr_i(addr_i), .line_i(line_i),
        .line_o(line_o), .hit_o(hit_o), .miss_o(miss_o), .old_addr_o(old_addr_o)
    );

    // reference model: 2 sets x 4 ways, set = addr[0]
    bit          m_valid [2][4];
    bit          m_def   [2][4];
    logic [3:0]  m_addr  [2][4];
    logic [15:0] m_data  [2][4];
    int          m_rank  [2][4];
    logic [15:0] exp_line;
    logic [3:0]  exp_old;
    bit          line_known, old_known;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic make_newest(input int s, input int w);
        int r = m_rank[s][w];
        for (int x = 0; x < 4; x++) begin
            if (x == w) m_rank[s][x] = 3;
            else if (m_rank[s][x] > r) m_rank[s][x]--;
        end
    endtask

    task automatic make_oldest(input int s, input int w);
        int r = m_rank[s][w];
        for (int x = 0; x < 4; x++) begin
            if (x == w) m_rank[s][x] = 0;
            else if (m_rank[s][x] < r) m_rank[s][x]++;
        end
    endtask

    function automatic int pick_victim(input int s);
        for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < 4; w++) if (m_rank[s][w] == 0) return w;
        return 0;
    endfunction

    task automatic step(input logic [3:0] pat, input logic [3:0] a,
                        input logic [15:0] d, input logic [1:0] mn, input string tag);
        int s = int'(a[0]);
        int hw = -1;
        int v;
        bit e_hit = 1'b0;
        bit e_miss = 1'b0;
        logic [15:0] mg;
        for (int w = 0; w < 4; w++)
            if (m_valid[s][w] && m_addr[s][w] == a) hw = w;
        case (pat)
            4'b1000, 4'b1100, 4'b1010, 4'b1110: begin
                e_hit  = (hw >= 0);
                e_miss = !e_hit;
                if (hw >= 0) begin
                    mg = m_data[s][hw];
                    if (pat[2])
                        for (int b = 0; b < 2; b++)
                            if (!mn[b]) mg[b*8 +: 8] = d[b*8 +: 8];
                    m_data[s][hw] = mg;
                    exp_line   = mg;
                    line_known = m_def[s][hw];
                    if (pat[1]) begin
                        m_valid[s][hw] = 1'b0;
                        make_oldest(s, hw);
                    end else begin
                        make_newest(s, hw);
                    end
                end
            end
            4'b0001: begin
                v = pick_victim(s);
                exp_line   = m_data[s][v];
                exp_old    = m_addr[s][v];
                line_known = m_def[s][v];
                old_known  = m_def[s][v];
            end
            4'b0101: begin
                v = pick_victim(s);
                m_data[s][v]  = d;
                m_addr[s][v]  = a;
                m_valid[s][v] = 1'b1;
                m_def[s][v]   = 1'b1;
                make_newest(s, v);
                exp_line   = d;
                line_known = 1'b1;
            end
            default: ;
        endcase
        {req_i, rw_i, inv_i, rep_i} = pat;
        addr_i    = a;
        line_i    = d;
        wmask_n_i = mn;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R4 hit"}, 32'(hit_o), 32'(e_hit));
        check({tag, " R4 miss"}, 32'(miss_o), 32'(e_miss));
        if (line_known) check({tag, " line"}, 32'(line_o), 32'(exp_line));
        if (old_known)  check({tag, " old_addr"}, 32'(old_addr_o), 32'(exp_old));
    endtask

    function automatic logic [15:0] pat_data(input int a, input int k);
        return 16'((a * 16'h1111) ^ (k * 16'h2d5b) ^ 16'h5a00);
    endfunction

    task automatic replace_line(input logic [3:0] a, input logic [15:0] d, input logic [1:0] mn);
        step(4'b0001, a, 16'hdead, mn, "R7 R9 victim read");
        step(4'b0101, a, d, mn, "R8 victim write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        {req_i, rw_i, inv_i, rep_i} = 4'b0000;
        wmask_n_i = 2'b00; addr_i = '0; line_i = '0;
        for (int s = 0; s < 2; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0; m_def[s][w] = 1'b0;
                m_rank[s][w] = w; m_addr[s][w] = '0; m_data[s][w] = '0;
            end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        check("R3 reset hit", 32'(hit_o), 0);
        check("R3 reset miss", 32'(miss_o), 0);
        check("R3 reset line", 32'(line_o), 0);
        check("R3 reset old_addr", 32'(old_addr_o), 0);
        exp_line = '0; exp_old = '0; line_known = 1'b1; old_known = 1'b1;

        // R3 R2: every address misses after reset
        for (int a = 0; a < 16; a++) step(4'b1000, 4'(a), '0, 2'b00, "R3 R2 empty read");
        // R1: unlisted patterns do nothing
        foreach (pat_nop[i]) step(pat_nop[i], 4'(i), 16'hffff, 2'b00, "R1 no-op");
        // R6 R11: writes that miss change nothing
        step(4'b1100, 4'd3, 16'h1234, 2'b00, "R6 update miss");
        step(4'b1110, 4'd4, 16'h1234, 2'b00, "R11 write-drop miss");

        // fill with eviction, mask ignored on victim write (R8)
        for (int a = 0; a < 16; a++) replace_line(4'(a), pat_data(a, 0), 2'(a));
        // R2 R5 R10: reads after fill
        for (int a = 15; a >= 0; a--) step(4'b1000, 4'(a), '0, 2'b00, "R2 R5 R10 read");
        // R6: masked updates over all mask values
        for (int a = 0; a < 16; a++) step(4'b1100, 4'(a), pat_data(a, 1), 2'(a >> 1), "R6 update");
        // R9 R10: new lines evict the oldest ways
        for (int a = 0; a < 6; a++) replace_line(4'(a), pat_data(a, 2), 2'b11);
        for (int a = 0; a < 16; a++) step(4'b1000, 4'(a), '0, 2'b00, "R5 R10 read");
        // R11: drops, then victims fall on the dropped ways
        for (int a = 0; a < 16; a += 3) step(4'b1010, 4'(a), '0, 2'b00, "R11 read-drop");
        for (int a = 1; a < 16; a += 4) step(4'b1110, 4'(a), pat_data(a, 3), 2'b01, "R11 write-drop");
        for (int a = 8; a < 16; a++) replace_line(4'(a), pat_data(a, 4), 2'b10);
        for (int a = 0; a < 16; a++) step(4'b1000, 4'(a), '0, 2'b00, "R9 R11 read");
        for (int a = 0; a < 16; a++) step(4'b1100, 4'(a), pat_data(a, 5), 2'(a), "R6 update2");
        for (int a = 0; a < 16; a++) step(4'b1000, 4'(a), '0, 2'b00, "R5 final read");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // patterns outside the command table
    logic [3:0] pat_nop [10] = '{4'b0000, 4'b1001, 4'b1101, 4'b1011, 4'b1111,
                                4'b0011, 4'b0111, 4'b0010, 4'b0100, 4'b0110};

endmodule